// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block links a host and a peer processor through two circular buffers of 32-bit slots: one carries words from host to peer, the other from peer to host. Each side reaches the block through its own simple 32-bit register port. The port has four word-spaced locations: a push window, the side's own control/status register (CSR), a pop window and a read-only view of the far side's CSR.

Occupancy is reported as free-running 8-bit write and read pointers plus the buffer depth. Software derives the filled count as the pointer difference modulo 256 and the free count as depth minus filled. Each CSR also carries an interrupt enable, a pending flag, a doorbell trigger, a ready flag, a reset-request flag and a sticky overflow flag. A side rings the other through the doorbell trigger. Raising reset-request empties both buffers and drops the far side's ready flag. This lets the two sides resynchronise through a handshake: request reset with a doorbell, wait for the far ready, then release reset with ready and doorbell set.

Top module: `dbell_mailbox`

## Requirements
- R1: After synchronous reset, both CSRs read depth in bits 31:24 and zero in every other bit, and both interrupt outputs are low.
- R2: A write to byte offset 0x0 pushes one word into the side's outbound buffer and advances that side's write pointer (CSR bits 23:16) by one. The far side reads words back in push order from offset 0x8, and each read advances the read pointer (CSR bits 15:8) by one.
- R3: A push into a full buffer (filled count equal to depth) stores nothing, leaves the pointers unchanged and sets the writer's overflow flag (CSR bit 5). The flag stays set until that side writes a 1 to bit 5.
- R4: A read of offset 0x8 while the inbound buffer is empty returns zero and leaves both pointers unchanged.
- R5: Pointers run freely modulo 256, so ordering and filled count stay correct when the write pointer wraps past the read pointer's numeric value.
- R6: Writing 1 to CSR bit 2 sends a one-cycle doorbell to the far side and sets the far side's pending flag (CSR bit 1). Bit 2 always reads 0.
- R7: A side's interrupt output is high exactly when its pending flag and its enable flag (CSR bit 0) are both set.
- R8: Writing 1 to bit 1 clears the pending flag, so reading the CSR and writing the value back clears it. Writing 0 to bit 1 leaves the flag unchanged.
- R9: A CSR write that sets reset-request (bit 4) while it was clear empties both buffers by moving each read pointer to its write pointer. It also clears the far side's ready flag (bit 3), which the far side may set again while the request is still held.
- R10: Offset 0xC returns the far side's CSR, and writes to offset 0xC have no effect.
- R11: Enable, ready and reset-request read back as last written by the side that owns the CSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel | input | 1 | Host access strobe |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | ADDR_W | Host byte address (bits 3:2 select the location) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after the access |
| hst_irq | output | 1 | Host interrupt |
| hst_bell | output | 1 | One-cycle doorbell pulse arriving at the host |
| per_sel | input | 1 | Peer access strobe |
| per_we | input | 1 | Peer access is a write |
| per_addr | input | ADDR_W | Peer byte address |
| per_wdata | input | 32 | Peer write data |
| per_rdata | output | 32 | Peer read data, valid the cycle after the access |
| per_irq | output | 1 | Peer interrupt |
| per_bell | output | 1 | One-cycle doorbell pulse arriving at the peer |

## Verification
The buffers are tried with a short burst that is pushed and then drained, an over-fill of one word past depth, reads of an empty buffer, and a long stream of 256 or more single push/pop pairs. Together these separate correct ordering from a lost or duplicated slot, a dropped word from a corrupted one, and correct modulo-256 arithmetic from a pointer that saturates. The control bits are tried with doorbells under enabled and disabled interrupts, pending clears that write 0 and then 1, and a full reset handshake with words still queued. These show whether set and clear priorities, the ready drop and the flush behave as required.

// File: rtl/mbx_pkg.sv
// Package: shared field positions, window offsets and CSR packing for the
// doorbell mailbox. Assumes 32-bit data and 8-bit free-running pointers.
package mbx_pkg;

    localparam int DATA_W = 32;
    localparam int PTR_W  = 8;

    // CSR bit positions
    localparam int F_IEN   = 0;
    localparam int F_IPEND = 1;
    localparam int F_RING  = 2;
    localparam int F_RDY   = 3;
    localparam int F_RSTQ  = 4;
    localparam int F_OVF   = 5;

    // Word-index of each location in a port (byte address bits 3:2)
    localparam logic [1:0] LOC_PUSH  = 2'd0;
    localparam logic [1:0] LOC_OWN   = 2'd1;
    localparam logic [1:0] LOC_POP   = 2'd2;
    localparam logic [1:0] LOC_OTHER = 2'd3;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        logic ovf;
        logic rstq;
        logic rdy;
        logic ipend;
        logic ien;
    } ctl_t;

    // Assemble a CSR image; the doorbell trigger always reads as 0.
    function automatic logic [DATA_W-1:0] pack_csr(input ptr_t depth,
                                                   input ptr_t wp,
                                                   input ptr_t rp,
                                                   input ctl_t c);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[31:24]   = depth;
        v[23:16]   = wp;
        v[15:8]    = rp;
        v[F_IEN]   = c.ien;
        v[F_IPEND] = c.ipend;
        v[F_RDY]   = c.rdy;
        v[F_RSTQ]  = c.rstq;
        v[F_OVF]   = c.ovf;
        return v;
    endfunction

endpackage

// File: rtl/mbx_ring.sv
// Module: one circular buffer of DEPTH 32-bit slots with free-running 8-bit
// pointers. Assumes DEPTH is a power of two between 2 and 128. A push when
// full and a pop when empty are ignored; flush wins over both.
module mbx_ring
    import mbx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output ptr_t              wp,
    output ptr_t              rp,
    output logic              full,
    output logic              empty
);
    localparam int   IDX_W  = $clog2(DEPTH);
    localparam ptr_t DEPTH8 = PTR_W'(DEPTH);

    logic [DATA_W-1:0] slots [DEPTH];
    ptr_t              fill;
    logic              push_ok;
    logic              pop_ok;

    // Occupancy and accept decisions
    always_comb begin
        fill    = wp - rp;
        full    = (fill == DEPTH8);
        empty   = (fill == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        head    = slots[rp[IDX_W-1:0]];
    end

    // Slot storage, written only on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok) slots[wp[IDX_W-1:0]] <= push_data;
    end

    // Pointer update: flush aligns read to write, else advance on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            rp <= wp;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
        end
    end

endmodule

// File: rtl/mbx_side.sv
// Module: control flags of one side's CSR. Assumes one CSR write per cycle.
// Doorbell arrival beats a pending clear; a far reset beats a ready write.
module mbx_side
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [DATA_W-1:0] csr_wd,
    input  logic              bell_in,
    input  logic              far_rst_rise,
    input  logic              ovf_hit,
    output ctl_t              ctl,
    output logic              bell_out,
    output logic              rst_rise,
    output logic              irq
);
    // Pulses generated by the current CSR write
    always_comb begin
        bell_out = csr_we && csr_wd[F_RING];
        rst_rise = csr_we && csr_wd[F_RSTQ] && !ctl.rstq;
        irq      = ctl.ien && ctl.ipend;
    end

    // Flag registers with their set/clear priorities
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (csr_we) begin
                ctl.ien  <= csr_wd[F_IEN];
                ctl.rstq <= csr_wd[F_RSTQ];
            end
            if (far_rst_rise)                   ctl.rdy <= 1'b0;
            else if (csr_we)                    ctl.rdy <= csr_wd[F_RDY];
            if (bell_in)                        ctl.ipend <= 1'b1;
            else if (csr_we && csr_wd[F_IPEND]) ctl.ipend <= 1'b0;
            if (ovf_hit)                        ctl.ovf <= 1'b1;
            else if (csr_we && csr_wd[F_OVF])   ctl.ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/mbx_port.sv
// Module: address decode and registered read mux for one side's register
// port. Assumes word-aligned accesses; byte address bits 3:2 pick location.
module mbx_port
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] own_csr,
    input  logic [DATA_W-1:0] far_csr,
    input  logic [DATA_W-1:0] pop_head,
    input  logic              pop_empty,
    output logic              push,
    output logic              pop,
    output logic              csr_we,
    output logic [DATA_W-1:0] rdata
);
    logic [1:0]        loc;
    logic [DATA_W-1:0] rd_mux;

    // Strobe decode and read source selection
    always_comb begin
        loc    = addr[3:2];
        push   = sel && we && (loc == LOC_PUSH);
        csr_we = sel && we && (loc == LOC_OWN);
        pop    = sel && !we && (loc == LOC_POP);
        unique case (loc)
            LOC_OWN:   rd_mux = own_csr;
            LOC_OTHER: rd_mux = far_csr;
            LOC_POP:   rd_mux = pop_empty ? '0 : pop_head;
            default:   rd_mux = '0;
        endcase
    end

    // Read data register, loaded on each read access
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (sel && !we) rdata <= rd_mux;
    end

endmodule

// File: rtl/dbell_mailbox.sv
// Module: two-way doorbell mailbox. Side 0 is the host, side 1 the peer.
// Ring k carries words written by side k and read by the other side. Assumes
// both sides share one clock; any reset request flushes both rings.
module dbell_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    output logic              hst_irq,
    output logic              hst_bell,
    input  logic              per_sel,
    input  logic              per_we,
    input  logic [ADDR_W-1:0] per_addr,
    input  logic [31:0]       per_wdata,
    output logic [31:0]       per_rdata,
    output logic              per_irq,
    output logic              per_bell
);
    localparam int   SIDES  = 2;
    localparam ptr_t DEPTH8 = PTR_W'(DEPTH);

    logic [SIDES-1:0]              b_sel, b_we;
    logic [SIDES-1:0][ADDR_W-1:0]  b_addr;
    logic [SIDES-1:0][DATA_W-1:0]  b_wdata, b_rdata;
    logic [SIDES-1:0][DATA_W-1:0]  csr_img, ring_head;
    logic [SIDES-1:0][PTR_W-1:0]   ring_wp, ring_rp;
    logic [SIDES-1:0]              ring_push, ring_pop, ring_full, ring_empty;
    logic [SIDES-1:0]              csr_we, bell_out, rst_rise, irq;
    logic [SIDES-1:0]              side_ipend, side_rdy;
    ctl_t                          side_ctl [SIDES];
    logic                          flush_all;

    // Fold the two external ports into side-indexed vectors
    always_comb begin
        b_sel   = {per_sel, hst_sel};
        b_we    = {per_we, hst_we};
        b_addr  = {per_addr, hst_addr};
        b_wdata = {per_wdata, hst_wdata};
    end

    assign flush_all = |rst_rise;

    for (genvar k = 0; k < SIDES; k++) begin : g_side
        localparam int FAR = SIDES - 1 - k;

        mbx_ring #(.DEPTH(DEPTH)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (ring_push[k]),
            .push_data (b_wdata[k]),
            .pop       (ring_pop[k]),
            .flush     (flush_all),
            .head      (ring_head[k]),
            .wp        (ring_wp[k]),
            .rp        (ring_rp[k]),
            .full      (ring_full[k]),
            .empty     (ring_empty[k])
        );

        mbx_side u_flags (
            .clk          (clk),
            .rst_n        (rst_n),
            .csr_we       (csr_we[k]),
            .csr_wd       (b_wdata[k]),
            .bell_in      (bell_out[FAR]),
            .far_rst_rise (rst_rise[FAR]),
            .ovf_hit      (ring_push[k] && ring_full[k] && !flush_all),
            .ctl          (side_ctl[k]),
            .bell_out     (bell_out[k]),
            .rst_rise     (rst_rise[k]),
            .irq          (irq[k])
        );

        // CSR image: own outbound ring pointers plus own flags
        assign csr_img[k]    = pack_csr(DEPTH8, ring_wp[k], ring_rp[k], side_ctl[k]);
        assign side_ipend[k] = side_ctl[k].ipend;
        assign side_rdy[k]   = side_ctl[k].rdy;

        // Side k pushes into ring k and pops from the far ring
        mbx_port #(.ADDR_W(ADDR_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (b_sel[k]),
            .we        (b_we[k]),
            .addr      (b_addr[k]),
            .own_csr   (csr_img[k]),
            .far_csr   (csr_img[FAR]),
            .pop_head  (ring_head[FAR]),
            .pop_empty (ring_empty[FAR]),
            .push      (ring_push[k]),
            .pop       (ring_pop[FAR]),
            .csr_we    (csr_we[k]),
            .rdata     (b_rdata[k])
        );
    end

    // Drive the external outputs from side-indexed results
    always_comb begin
        hst_rdata = b_rdata[0];
        per_rdata = b_rdata[1];
        hst_irq   = irq[0];
        per_irq   = irq[1];
        hst_bell  = bell_out[1];
        per_bell  = bell_out[0];
    end

endmodule

// File: rtl/dbell_mailbox_chk.sv
// Module: protocol checker for the doorbell mailbox, bound to the top.
module dbell_mailbox_chk #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0][7:0]  ring_wp,
    input logic [1:0][7:0]  ring_rp,
    input logic [1:0]       ring_push,
    input logic [1:0]       ring_pop,
    input logic             flush_all,
    input logic [1:0]       bell_out,
    input logic [1:0]       rst_rise,
    input logic [1:0]       side_ipend,
    input logic [1:0]       side_rdy
);
    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    for (genvar k = 0; k < 2; k++) begin : g_chk
        localparam int FAR = 1 - k;
        logic [7:0] fill;
        assign fill = ring_wp[k] - ring_rp[k];

        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fill <= DEPTH8);

        assert_push_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ring_push[k] && fill < DEPTH8 && !flush_all)
            |=> ring_wp[k] == 8'($past(ring_wp[k]) + 8'd1));

        assert_empty_pop_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ring_pop[k] && fill == 8'd0 && !flush_all) |=> $stable(ring_rp[k]));

        assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
            flush_all |=> ring_wp[k] == ring_rp[k]);

        assert_bell_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
            bell_out[k] |=> side_ipend[FAR]);

        assert_ready_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rst_rise[k] |=> !side_rdy[FAR]);
    end

endmodule

bind dbell_mailbox dbell_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_wp    (ring_wp),
    .ring_rp    (ring_rp),
    .ring_push  (ring_push),
    .ring_pop   (ring_pop),
    .flush_all  (flush_all),
    .bell_out   (bell_out),
    .rst_rise   (rst_rise),
    .side_ipend (side_ipend),
    .side_rdy   (side_rdy)
);

// File: tb/dbell_mailbox_tb.sv
`timescale 1ns/1ps
module dbell_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 0, hst_we = 0, per_sel = 0, per_we = 0;
    logic [3:0]  hst_addr = 0, per_addr = 0;
    logic [31:0] hst_wdata = 0, per_wdata = 0;
    logic [31:0] hst_rdata, per_rdata;
    logic        hst_irq, hst_bell, per_irq, per_bell;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    dbell_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .hst_sel(hst_sel), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_irq(hst_irq), .hst_bell(hst_bell),
        .per_sel(per_sel), .per_we(per_we), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata),
        .per_irq(per_irq), .per_bell(per_bell)
    );

    // Vector: {side(0 host,1 peer), write, byte addr, wdata or expected rdata}
    localparam int NV = 20;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'h4, 32'h0800_0000},
        {1'b1, 1'b0, 4'h4, 32'h0800_0000},
        {1'b0, 1'b1, 4'h0, 32'h0000_00A1},
        {1'b0, 1'b1, 4'h0, 32'h0000_00B2},
        {1'b0, 1'b1, 4'h0, 32'h0000_00C3},
        {1'b0, 1'b0, 4'h4, 32'h0803_0000},
        {1'b1, 1'b0, 4'hC, 32'h0803_0000},
        {1'b1, 1'b0, 4'h8, 32'h0000_00A1},
        {1'b1, 1'b0, 4'h8, 32'h0000_00B2},
        {1'b0, 1'b0, 4'h4, 32'h0803_0200},
        {1'b1, 1'b0, 4'h8, 32'h0000_00C3},
        {1'b1, 1'b0, 4'h8, 32'h0000_0000},
        {1'b0, 1'b0, 4'h4, 32'h0803_0300},
        {1'b1, 1'b1, 4'h0, 32'h0000_0055},
        {1'b0, 1'b0, 4'h8, 32'h0000_0055},
        {1'b0, 1'b0, 4'hC, 32'h0801_0100},
        {1'b0, 1'b1, 4'hC, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 4'hC, 32'h0801_0100},
        {1'b0, 1'b1, 4'h4, 32'h0000_0009},
        {1'b0, 1'b0, 4'h4, 32'h0803_0309}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:             return "R1";
            5, 7, 8, 9, 10:   return "R2";
            11, 12:           return "R4";
            15, 17:           return "R10";
            19:               return "R11";
            default:          return "R2";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; read data is sampled one cycle later, away from the edge
    task automatic op(input bit side, input bit wr, input logic [3:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        if (!side) begin hst_sel = 1; hst_we = wr; hst_addr = a; hst_wdata = d; end
        else       begin per_sel = 1; per_we = wr; per_addr = a; per_wdata = d; end
        @(negedge clk);
        hst_sel = 0; per_sel = 0; hst_we = 0; per_we = 0;
        rd = side ? per_rdata : hst_rdata;
    endtask

    task automatic wr(input bit side, input logic [3:0] a, input logic [31:0] d);
        logic [31:0] unused;
        op(side, 1'b1, a, d, unused);
    endtask

    task automatic rdc(input bit side, input logic [3:0] a, input logic [31:0] exp,
                       input string tag);
        logic [31:0] r;
        op(side, 1'b0, a, 32'h0, r);
        chk(r, exp, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk({31'b0, hst_irq}, 0, "R1");
        chk({31'b0, per_irq}, 0, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) wr(VEC[i][37], VEC[i][35:32], VEC[i][31:0]);
            else            rdc(VEC[i][37], VEC[i][35:32], VEC[i][31:0], vec_tag(i));
        end

        // Doorbell, pending, interrupt gating (R6 R7 R8)
        wr(1, 4'h4, 32'h1);
        wr(0, 4'h4, 32'hD);
        rdc(1, 4'h4, 32'h0801_0103, "R6");
        rdc(0, 4'h4, 32'h0803_0309, "R6");
        chk({31'b0, per_irq}, 1, "R7");
        wr(1, 4'h4, 32'h1);
        rdc(1, 4'h4, 32'h0801_0103, "R8");
        wr(1, 4'h4, 32'h3);
        rdc(1, 4'h4, 32'h0801_0101, "R8");
        chk({31'b0, per_irq}, 0, "R7");
        wr(0, 4'h4, 32'h8);
        wr(1, 4'h4, 32'h5);
        rdc(0, 4'h4, 32'h0803_030A, "R6");
        chk({31'b0, hst_irq}, 0, "R7");
        wr(0, 4'h4, 32'h9);
        chk({31'b0, hst_irq}, 1, "R7");
        wr(0, 4'h4, 32'hB);
        chk({31'b0, hst_irq}, 0, "R8");

        // Reset handshake with words queued on both rings (R9)
        wr(1, 4'h4, 32'h9);
        wr(0, 4'h0, 32'h11);
        wr(0, 4'h0, 32'h22);
        wr(1, 4'h0, 32'h33);
        wr(0, 4'h4, 32'h1D);
        rdc(0, 4'h4, 32'h0805_0519, "R9");
        rdc(1, 4'h4, 32'h0802_0203, "R9");
        rdc(1, 4'h8, 32'h0, "R9");
        wr(1, 4'h4, 32'hB);
        rdc(1, 4'h4, 32'h0802_0209, "R9");
        wr(0, 4'h4, 32'hD);
        rdc(0, 4'h4, 32'h0805_0509, "R11");
        rdc(1, 4'h4, 32'h0802_020B, "R9");

        // Over-fill by one word (R3)
        for (int i = 0; i < 9; i++) wr(0, 4'h0, 32'h100 + i);
        rdc(0, 4'h4, 32'h080D_0529, "R3");
        for (int i = 0; i < 8; i++) rdc(1, 4'h8, 32'h100 + i, "R3");
        rdc(1, 4'h8, 32'h0, "R3");
        rdc(0, 4'h4, 32'h080D_0D29, "R3");
        wr(0, 4'h4, 32'h29);
        rdc(0, 4'h4, 32'h080D_0D09, "R3");

        // Pointer wrap on the peer-to-host ring (R5)
        for (int i = 0; i < 253; i++) begin
            wr(1, 4'h0, 32'hA000 + i);
            rdc(0, 4'h8, 32'hA000 + i, "R5");
        end
        for (int i = 0; i < 3; i++) wr(1, 4'h0, 32'hB000 + i);
        rdc(0, 4'hC, 32'h0802_FF0B, "R5");
        for (int i = 0; i < 3; i++) rdc(0, 4'h8, 32'hB000 + i, "R5");
        rdc(0, 4'hC, 32'h0802_020B, "R5");

        // Mid-run reset returns to the reset state (R1)
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        chk({31'b0, hst_irq}, 0, "R1");
        chk({31'b0, per_irq}, 0, "R1");
        rdc(0, 4'h4, 32'h0800_0000, "R1");
        rdc(0, 4'hC, 32'h0800_0000, "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule